// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a two-bank SDRAM refreshed without help from the read/write path. A free-running interval counter produces one refresh credit per tick. The tick period is set so that 2048 refreshes land inside every 32 ms window, which is about one every 15.6 µs. Credits collect in a small saturating pending counter. Whenever at least one credit is held, the block raises a bus request to the command arbiter.

When the arbiter grants, the block owns the command bus until its sequence ends. An auto-refresh is legal only with every bank precharged. So if any bank reports an open row at the grant, the block first drives a precharge-all (A10 high, bank select ignored) and waits the row-precharge time. It then drives the auto-refresh and waits the row-cycle time before it gives the bus back. Each accepted grant consumes one credit.

When the pending count reaches its limit, an urgent flag tells the arbiter to stop postponing. The tick interval, precharge time and row-cycle time are parameters counted in clock cycles. The tick interval is rounded down so the deadline is never missed. The precharge and row-cycle times are rounded up.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `req_o` and `urgent_o` are low, `a10_o` is low, and `cmd_o` shows NOP. `cmd_o` is coded {cs_n, ras_n, cas_n, we_n}: NOP = 4'b0111, precharge = 4'b0010, auto-refresh = 4'b0001.
- R2: The interval counter adds one pending refresh every `TICK_CYC` cycles. With no grant, `req_o` first rises exactly `TICK_CYC` clock edges after reset is released.
- R3: While idle with refreshes pending and no grant, `req_o` stays high and `cmd_o` stays NOP.
- R4: A grant while any bit of `bank_open_i` is high puts precharge with `a10_o` = 1 on `cmd_o` in the cycle after the grant edge.
- R5: After a precharge, auto-refresh appears on `cmd_o` exactly `TRP_CYC` cycles later, with NOP in between and `a10_o` low.
- R6: A grant while every bank is idle skips the precharge. Auto-refresh appears in the cycle after the grant edge.
- R7: After an auto-refresh, `cmd_o` stays NOP and `req_o` stays high (bus held) for `TRC_CYC`-1 cycles. In cycle `TRC_CYC` after it, the block is idle and `req_o` reflects the pending count.
- R8: The pending count saturates at `MAX_PEND` (8). `urgent_o` is high exactly when the count equals `MAX_PEND`.
- R9: Each accepted grant removes one pending refresh. A grant accepted on the same edge as a tick leaves the count unchanged.
- R10: `gnt_i` has no effect while a precharge/refresh sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open_i | input | NBANK | Per-bank row-open status, 1 = open |
| gnt_i | input | 1 | Arbiter grant of the command bus |
| req_o | output | 1 | Bus request / bus hold |
| urgent_o | output | 1 | Pending count at its limit |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| a10_o | output | 1 | A10 value, high for precharge-all |

## Verification
The bench grants with one bank open, with both banks open and with neither open. This separates the precharge-first path from the direct refresh path and checks the exact precharge-to-refresh and refresh-to-release spacings. Grants are pulsed during the row-cycle wait to show they are ignored. A long stretch without grants fills the pending counter past its limit. Draining it then shows exactly eight sequences and the urgent flag clearing. A grant timed onto a tick edge tells apart a counter that merges increment and decrement from one that loses either.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    // command code {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP    = 4'b0111,
        CMD_PREALL = 4'b0010,
        CMD_AREF   = 4'b0001
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_PWAIT,
        SQ_REF,
        SQ_RWAIT
    } seq_st_e;

endpackage

// File: rtl/refsch_tick.sv
module refsch_tick #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int IV = (INTERVAL < 2) ? 2 : INTERVAL;
    localparam int W  = $clog2(IV);
    localparam logic [W-1:0] LAST = W'(IV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.cnt == LAST);

    // R2: ticks are isolated pulses
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/refsch_pend.sv
module refsch_pend #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic nz_o,
    output logic full_o
);
    localparam int W = $clog2(MAX_PEND + 1);
    localparam logic [W-1:0] TOP = W'(MAX_PEND);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc_i, dec_i})
            2'b10: if (st_q.cnt != TOP)  st_d.cnt = st_q.cnt + 1'b1;
            2'b01: if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nz_o   = (st_q.cnt != '0);
    assign full_o = (st_q.cnt == TOP);

    // R8: never beyond the limit
    a_r8_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);

    // R9: a lone decrement of a nonzero count removes exactly one
    a_r9_pend_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && nz_o) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
    import refsch_pkg::*;
#(
    parameter int NBANK   = 2,
    parameter int TRP_CYC = 1,
    parameter int TRC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_nz_i,
    input  logic [NBANK-1:0] bank_open_i,
    input  logic             gnt_i,
    output logic             take_o,
    output logic             req_o,
    output sdr_cmd_e         cmd_o,
    output logic             a10_o
);
    localparam int TRP  = (TRP_CYC < 1) ? 1 : TRP_CYC;
    localparam int TRC  = (TRC_CYC < 2) ? 2 : TRC_CYC;
    localparam int WMAX = (TRP > TRC) ? TRP : TRC;
    localparam int WW   = $clog2(WMAX + 1);
    localparam logic [WW-1:0] PRE_LOAD = (TRP >= 2) ? WW'(TRP - 2) : '0;
    localparam logic [WW-1:0] REF_LOAD = WW'(TRC - 2);

    typedef struct packed {
        seq_st_e       st;
        logic [WW-1:0] wait_cnt;
    } seq_t;

    seq_t s_d, s_q;

    assign take_o = (s_q.st == SQ_IDLE) && pend_nz_i && gnt_i;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (take_o) s_d.st = (|bank_open_i) ? SQ_PRE : SQ_REF;
            end
            SQ_PRE: begin
                if (TRP == 1) begin
                    s_d.st = SQ_REF;
                end else begin
                    s_d.st       = SQ_PWAIT;
                    s_d.wait_cnt = PRE_LOAD;
                end
            end
            SQ_PWAIT: begin
                if (s_q.wait_cnt == '0) s_d.st = SQ_REF;
                else                    s_d.wait_cnt = s_q.wait_cnt - 1'b1;
            end
            SQ_REF: begin
                s_d.st       = SQ_RWAIT;
                s_d.wait_cnt = REF_LOAD;
            end
            SQ_RWAIT: begin
                if (s_q.wait_cnt == '0) s_d.st = SQ_IDLE;
                else                    s_d.wait_cnt = s_q.wait_cnt - 1'b1;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st       <= SQ_IDLE;
            s_q.wait_cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cmd_o = CMD_NOP;
        a10_o = 1'b0;
        if (s_q.st == SQ_PRE) begin
            cmd_o = CMD_PREALL;
            a10_o = 1'b1;
        end else if (s_q.st == SQ_REF) begin
            cmd_o = CMD_AREF;
        end
    end

    assign req_o = (s_q.st == SQ_IDLE) ? pend_nz_i : 1'b1;

    // R3: an ungranted request is not withdrawn
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_IDLE && req_o && !gnt_i) |=> req_o);

    // R4: precharge follows a grant seen with an open bank
    a_r4_pre_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREALL) |-> ($past(gnt_i) && $past(|bank_open_i)));

    // R7: the cycle after a refresh carries no command
    a_r7_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_AREF) |=> (cmd_o == CMD_NOP && req_o));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int NBANK    = 2,
    parameter int TICK_CYC = 780,
    parameter int TRP_CYC  = 1,
    parameter int TRC_CYC  = 4,
    parameter int MAX_PEND = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] bank_open_i,
    input  logic             gnt_i,
    output logic             req_o,
    output logic             urgent_o,
    output logic [3:0]       cmd_o,
    output logic             a10_o
);
    logic     tick;
    logic     pend_nz;
    logic     take;
    sdr_cmd_e seq_cmd;

    refsch_tick #(.INTERVAL(TICK_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    refsch_pend #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (tick),
        .dec_i  (take),
        .nz_o   (pend_nz),
        .full_o (urgent_o)
    );

    refsch_seq #(
        .NBANK   (NBANK),
        .TRP_CYC (TRP_CYC),
        .TRC_CYC (TRC_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_nz_i   (pend_nz),
        .bank_open_i (bank_open_i),
        .gnt_i       (gnt_i),
        .take_o      (take),
        .req_o       (req_o),
        .cmd_o       (seq_cmd),
        .a10_o       (a10_o)
    );

    assign cmd_o = seq_cmd;

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
    localparam int TICK = 200;
    localparam int TRP  = 3;
    localparam int TRC  = 5;
    localparam int MAXP = 8;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_open = 2'b00;
    logic       gnt = 1'b0;
    logic       req, urgent, a10;
    logic [3:0] cmd;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    refresh_sched #(
        .NBANK(2), .TICK_CYC(TICK), .TRP_CYC(TRP), .TRC_CYC(TRC), .MAX_PEND(MAXP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open), .gnt_i(gnt),
        .req_o(req), .urgent_o(urgent), .cmd_o(cmd), .a10_o(a10)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // one granted sequence; ends at the negedge of the first idle cycle
    task automatic run_seq(input logic [1:0] open, input bit exp_pre);
        chk(req == 1'b1, "R3 req before grant", req, 1);
        bank_open = open;
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        bank_open = 2'b00;
        if (exp_pre) begin
            chk(cmd == C_PRE, "R4 precharge after grant", cmd, C_PRE);
            chk(a10 == 1'b1, "R4 a10 on precharge", a10, 1);
            for (int i = 0; i < TRP - 1; i++) begin
                @(negedge clk);
                chk(cmd == C_NOP, "R5 nop in tRP", cmd, C_NOP);
            end
            @(negedge clk);
        end
        chk(cmd == C_REF, exp_pre ? "R5 refresh after tRP" : "R6 direct refresh", cmd, C_REF);
        chk(a10 == 1'b0, "R5 a10 low on refresh", a10, 0);
        for (int i = 0; i < TRC - 1; i++) begin
            gnt = 1'b1; // R10: must be ignored
            @(negedge clk);
            chk(cmd == C_NOP && req == 1'b1, "R7 quiet bus hold", {req, cmd}, {1'b1, C_NOP});
        end
        gnt = 1'b0;
        @(negedge clk);
        chk(cmd == C_NOP, "R10 no extra command", cmd, C_NOP);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(req == 1'b0 && urgent == 1'b0, "R1 req/urgent reset", {req, urgent}, 0);
        chk(cmd == C_NOP && a10 == 1'b0, "R1 cmd reset", {a10, cmd}, C_NOP);
        rst_n = 1'b1;
    endtask

    task automatic t_first_tick();
        int edges = 0;
        bit cmd_ok = 1'b1;
        while (!req && edges < 3 * TICK) begin
            @(negedge clk);
            edges++;
            if (cmd != C_NOP) cmd_ok = 1'b0;
        end
        chk(edges == TICK, "R2 first request delay", edges, TICK);
        chk(cmd_ok, "R3 no command before grant", cmd_ok, 1);
    endtask

    task automatic t_hold();
        bit held = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!req || cmd != C_NOP) held = 1'b0;
        end
        chk(held, "R3 request held without grant", held, 1);
    endtask

    task automatic t_one_open();
        run_seq(2'b01, 1'b1);
        chk(req == 1'b0, "R9 count back to zero", req, 0);
    endtask

    task automatic t_all_idle();
        wait_until(2 * TICK);
        @(negedge clk);
        run_seq(2'b00, 1'b0);
        chk(req == 1'b0, "R6 count back to zero", req, 0);
    endtask

    task automatic t_both_open();
        wait_until(3 * TICK);
        @(negedge clk);
        run_seq(2'b11, 1'b1);
        chk(req == 1'b0, "R4 count back to zero", req, 0);
    endtask

    task automatic t_saturate();
        int n = 0;
        wait_until(10 * TICK);
        chk(urgent == 1'b0, "R8 not urgent at 7", urgent, 0);
        wait_until(11 * TICK);
        chk(urgent == 1'b1, "R8 urgent at 8", urgent, 1);
        wait_until(12 * TICK);
        chk(urgent == 1'b1, "R8 saturated", urgent, 1);
        while (req && n < 20) begin
            run_seq(2'b00, 1'b0);
            n++;
            if (n == 1) chk(urgent == 1'b0, "R8 urgent clears", urgent, 0);
        end
        chk(n == MAXP, "R9 drained sequences", n, MAXP);
    endtask

    task automatic t_simul();
        wait_until(13 * TICK);
        chk(req == 1'b1, "R2 one pending", req, 1);
        wait_until(14 * TICK - 1);
        run_seq(2'b00, 1'b0); // grant lands on tick edge
        chk(req == 1'b1, "R9 tick and grant together", req, 1);
        run_seq(2'b00, 1'b0);
        chk(req == 1'b0, "R9 last credit used", req, 0);
    endtask

    initial begin
        t_reset();
        t_first_tick();
        t_hold();
        t_one_open();
        t_all_idle();
        t_both_open();
        t_saturate();
        t_simul();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 14 * TICK);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule